// File: doc/BRIEF.md
# Load and Store Ordering Queue

This block keeps the memory operations of an out-of-order core in program order between dispatch and retirement. It has two circular queues, one for loads and one for stores. Dispatch inserts each operation with its sequence number. For a store, dispatch also supplies the address, the data, the byte size and a prefetch marker. On insert the block reports the slot the operation took and the tail of the other queue at that moment. This link lets later ordering checks find the operations that are older and younger than it.

Commit sends the youngest retired sequence number, and the block latches it as a bound. Loads at the head that are at or below the bound leave the queue. A retired store is not freed at once. It is flagged as eligible for writeback and stays in the queue until it drains to the data-cache write port. Draining follows a request/ready handshake and pauses while the cache reports that it is blocked. A head store marked as a prefetch is freed without a cache write. When a branch mispredicts, a squash trims from each tail every entry younger than the squash point.

Top module: `mem_order_queue`

## Requirements
- R1: After reset both queues are empty, no store is eligible for writeback, and `wrValid` is low.
- R2: Each queue holds at most its configured capacity, and one more internal slot stays unused. A queue is full when its tail plus one, modulo the slot count, equals its head. An insert into a full queue is dropped, `insOverflow` is high in that cycle, and the occupancy does not change.
- R3: When an insert is accepted, `allocIdx` gives the slot it takes (its queue's tail). For a load, `allocPeer` gives the store-queue tail, and `allocPeerValid` is 0 when the store queue is empty. For a store, `allocPeer` gives the load-queue tail and `allocPeerValid` is 1.
- R4: After a commit bound is latched, the load queue frees one head entry per cycle for as long as the head's sequence number is less than or equal to the bound.
- R5: Stores are flagged write-eligible one per cycle, oldest first. `eligibleCount` stops at the first store whose sequence number is greater than the bound.
- R6: When the head store is eligible, is not a prefetch and the cache is not blocked, `wrValid` is high. `wrAddr`, `wrData` and `wrSize` then carry that store's address, data and size. The store is freed in the cycle `wrReady` is also high. Stores drain oldest first, at most one per cycle.
- R7: While `cacheBlocked` is high, `wrValid` stays low and no store is freed.
- R8: An eligible head store marked as a prefetch is freed in one cycle, and no cache write request is raised for it.
- R9: A store insert whose size is not 1, 2, 4 or 8 bytes is rejected. `sizeError` is high in that cycle.
- R10: A squash removes from each queue every entry whose sequence number is greater than `squashSeq`. It moves each tail back to the oldest removed slot and takes removed stores off the write-eligible count.
- R11: In a cycle with a squash, no insert is accepted and no overflow is reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| insValid | input | 1 | Insert request from dispatch |
| insIsStore | input | 1 | 1 = store, 0 = load |
| insSeq | input | SEQ_W | Sequence number of the inserted operation |
| insAddr | input | ADDR_W | Store address |
| insData | input | DATA_W | Store data |
| insSize | input | 4 | Store size in bytes |
| insPrefetch | input | 1 | Store is a data prefetch (no cache write) |
| commitValid | input | 1 | Latch a new commit bound |
| commitSeq | input | SEQ_W | Youngest committed sequence number |
| squashValid | input | 1 | Squash request |
| squashSeq | input | SEQ_W | Entries younger than this are removed |
| cacheBlocked | input | 1 | Data cache cannot accept writes |
| wrReady | input | 1 | Data cache accepts the write request |
| wrValid | output | 1 | Write request to the data cache |
| wrAddr | output | ADDR_W | Write address |
| wrData | output | DATA_W | Write data |
| wrSize | output | 4 | Write size in bytes |
| insOverflow | output | 1 | Insert dropped because the queue is full |
| sizeError | output | 1 | Store insert with an illegal size |
| allocIdx | output | PTR_W | Slot taken by the insert |
| allocPeer | output | PTR_W | Tail of the other queue at insert |
| allocPeerValid | output | 1 | `allocPeer` is meaningful |
| loadCount | output | CNT_W | Loads held |
| storeCount | output | CNT_W | Stores held, eligible ones included |
| eligibleCount | output | CNT_W | Stores flagged for writeback |

## Verification
The bench builds the block with three entries per queue, so each queue has four slots and two-bit indices. Filling to overflow, the wrap of the tail past the last slot, and a squash that removes both flagged and unflagged stores all take only a few cycles. A sweep of repeated insert-and-commit rounds walks the load tail through every slot more than once. At each step the bench computes the expected slot number modulo four. Small 8-bit sequence numbers and 16-bit data keep every expected address, data value and count easy to derive by hand.

// File: rtl/moq_pkg.sv
package moq_pkg;

  // Strobes from the control to the storage, all for the current cycle.
  typedef struct packed {
    logic ldPush;
    logic stPush;
    logic ldPop;
    logic stPop;
    logic stMark;
    logic squash;
  } moq_strobe_t;

  function automatic logic legalSize(input logic [3:0] sz);
    return (sz == 4'd1) || (sz == 4'd2) || (sz == 4'd4) || (sz == 4'd8);
  endfunction

endpackage

// File: rtl/moq_data.sv
module moq_data
  import moq_pkg::*;
#(
  parameter int LQ_SIZE = 9,
  parameter int SQ_SIZE = 9,
  parameter int PTR_W   = 4,
  parameter int CNT_W   = 4,
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  moq_strobe_t       strobe,
  input  logic [PTR_W-1:0]  ldHead,
  input  logic [PTR_W-1:0]  ldTail,
  input  logic [CNT_W-1:0]  ldCount,
  input  logic [PTR_W-1:0]  stHead,
  input  logic [PTR_W-1:0]  stTail,
  input  logic [CNT_W-1:0]  stCount,
  input  logic [PTR_W-1:0]  markPtr,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [DATA_W-1:0] insData,
  input  logic [3:0]        insSize,
  input  logic              insPrefetch,
  input  logic [SEQ_W-1:0]  squashSeq,
  output logic [SEQ_W-1:0]  ldHeadSeq,
  output logic              stHeadFlag,
  output logic              stHeadPrefetch,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [3:0]        headSize,
  output logic [SEQ_W-1:0]  markSeq,
  output logic [CNT_W-1:0]  ldKeep,
  output logic [CNT_W-1:0]  stKeep,
  output logic [CNT_W-1:0]  stFlagDrop
);

  logic [SEQ_W-1:0]  ldSeq   [LQ_SIZE];
  logic              ldLive  [LQ_SIZE];
  logic [SEQ_W-1:0]  stSeq   [SQ_SIZE];
  logic [ADDR_W-1:0] stAddr  [SQ_SIZE];
  logic [DATA_W-1:0] stData  [SQ_SIZE];
  logic [3:0]        stSize  [SQ_SIZE];
  logic              stPf    [SQ_SIZE];
  logic              stFlag  [SQ_SIZE];
  logic              stLive  [SQ_SIZE];

  logic [LQ_SIZE-1:0] ldDrop;
  logic [SQ_SIZE-1:0] stDrop;

  assign ldHeadSeq      = ldSeq[ldHead];
  assign stHeadFlag     = stFlag[stHead];
  assign stHeadPrefetch = stPf[stHead];
  assign headAddr       = stAddr[stHead];
  assign headData       = stData[stHead];
  assign headSize       = stSize[stHead];
  assign markSeq        = stSeq[markPtr];

  // Walk each queue from its head; count survivors of a squash and mark
  // the slots that a squash would remove.
  always_comb begin
    logic [PTR_W-1:0] idx;
    int unsigned s;
    ldKeep = '0;
    ldDrop = '0;
    for (int o = 0; o < LQ_SIZE; o++) begin
      s = int'(ldHead) + o;
      if (s >= LQ_SIZE) s = s - LQ_SIZE;
      idx = PTR_W'(s);
      if (CNT_W'(o) < ldCount) begin
        if (ldSeq[idx] > squashSeq) ldDrop[idx] = 1'b1;
        else                        ldKeep = ldKeep + CNT_W'(1);
      end
    end
  end

  always_comb begin
    logic [PTR_W-1:0] idx;
    int unsigned s;
    stKeep     = '0;
    stFlagDrop = '0;
    stDrop     = '0;
    for (int o = 0; o < SQ_SIZE; o++) begin
      s = int'(stHead) + o;
      if (s >= SQ_SIZE) s = s - SQ_SIZE;
      idx = PTR_W'(s);
      if (CNT_W'(o) < stCount) begin
        if (stSeq[idx] > squashSeq) begin
          stDrop[idx] = 1'b1;
          if (stFlag[idx]) stFlagDrop = stFlagDrop + CNT_W'(1);
        end else begin
          stKeep = stKeep + CNT_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < LQ_SIZE; i++) begin
        ldSeq[i]  <= '0;
        ldLive[i] <= 1'b0;
      end
    end else begin
      if (strobe.squash) begin
        for (int i = 0; i < LQ_SIZE; i++)
          if (ldDrop[i]) ldLive[i] <= 1'b0;
      end
      if (strobe.ldPop) ldLive[ldHead] <= 1'b0;
      if (strobe.ldPush) begin
        ldSeq[ldTail]  <= insSeq;
        ldLive[ldTail] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SQ_SIZE; i++) begin
        stSeq[i]  <= '0;
        stAddr[i] <= '0;
        stData[i] <= '0;
        stSize[i] <= '0;
        stPf[i]   <= 1'b0;
        stFlag[i] <= 1'b0;
        stLive[i] <= 1'b0;
      end
    end else begin
      if (strobe.squash) begin
        for (int i = 0; i < SQ_SIZE; i++)
          if (stDrop[i]) begin
            stFlag[i] <= 1'b0;
            stLive[i] <= 1'b0;
          end
      end
      if (strobe.stMark) stFlag[markPtr] <= 1'b1;
      if (strobe.stPop) begin
        stFlag[stHead] <= 1'b0;
        stLive[stHead] <= 1'b0;
      end
      if (strobe.stPush) begin
        stSeq[stTail]  <= insSeq;
        stAddr[stTail] <= insAddr;
        stData[stTail] <= insData;
        stSize[stTail] <= insSize;
        stPf[stTail]   <= insPrefetch;
        stFlag[stTail] <= 1'b0;
        stLive[stTail] <= 1'b1;
      end
    end
  end

  // R4: an occupied load queue always has a live entry at its head
  a_r4_head_live: assert property (@(posedge clk) disable iff (!rstN)
    (ldCount != '0) |-> ldLive[ldHead]);

  // R6: a store leaving the queue through writeback was flagged eligible
  a_r6_pop_flagged: assert property (@(posedge clk) disable iff (!rstN)
    strobe.stPop |-> (stFlag[stHead] && stLive[stHead]));

  // R10: after a squash, nothing younger than the squash point remains at the store tail
  a_r10_tail_trimmed: assert property (@(posedge clk) disable iff (!rstN)
    strobe.squash |=> (stCount == $past(stKeep)));

endmodule

// File: rtl/moq_ctrl.sv
module moq_ctrl
  import moq_pkg::*;
#(
  parameter int LQ_CAP = 8,
  parameter int SQ_CAP = 8,
  parameter int PTR_W  = 4,
  parameter int CNT_W  = 4,
  parameter int SEQ_W  = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             insValid,
  input  logic             insIsStore,
  input  logic [3:0]       insSize,
  input  logic             commitValid,
  input  logic [SEQ_W-1:0] commitSeq,
  input  logic             squashValid,
  input  logic             cacheBlocked,
  input  logic             wrReady,
  input  logic [SEQ_W-1:0] ldHeadSeq,
  input  logic             stHeadFlag,
  input  logic             stHeadPrefetch,
  input  logic [SEQ_W-1:0] markSeq,
  input  logic [CNT_W-1:0] ldKeep,
  input  logic [CNT_W-1:0] stKeep,
  input  logic [CNT_W-1:0] stFlagDrop,
  output moq_strobe_t      strobe,
  output logic [PTR_W-1:0] ldHead,
  output logic [PTR_W-1:0] ldTail,
  output logic [CNT_W-1:0] ldCount,
  output logic [PTR_W-1:0] stHead,
  output logic [PTR_W-1:0] stTail,
  output logic [CNT_W-1:0] stCount,
  output logic [CNT_W-1:0] eligCnt,
  output logic [PTR_W-1:0] markPtr,
  output logic             wrValid,
  output logic             insOverflow,
  output logic             sizeError,
  output logic [PTR_W-1:0] allocIdx,
  output logic [PTR_W-1:0] allocPeer,
  output logic             allocPeerValid
);

  localparam int LQ_SIZE = LQ_CAP + 1;
  localparam int SQ_SIZE = SQ_CAP + 1;

  function automatic logic [PTR_W-1:0] wrapAdd(input logic [PTR_W-1:0] base,
                                               input logic [CNT_W-1:0] off,
                                               input int unsigned size);
    int unsigned s;
    s = int'(base) + int'(off);
    if (s >= size) s = s - size;
    return PTR_W'(s);
  endfunction

  logic [SEQ_W-1:0] bound;
  logic             boundValid;
  logic             ldFull;
  logic             stFull;
  logic             canIns;
  logic             sizeOk;
  logic             wbGo;

  assign ldFull  = (wrapAdd(ldTail, CNT_W'(1), LQ_SIZE) == ldHead);
  assign stFull  = (wrapAdd(stTail, CNT_W'(1), SQ_SIZE) == stHead);
  assign canIns  = insValid && !squashValid;
  assign sizeOk  = legalSize(insSize);
  assign markPtr = wrapAdd(stHead, eligCnt, SQ_SIZE);

  assign wbGo    = !squashValid && (eligCnt != '0) && stHeadFlag && !cacheBlocked;
  assign wrValid = wbGo && !stHeadPrefetch;

  always_comb begin
    strobe        = '0;
    strobe.squash = squashValid;
    strobe.ldPush = canIns && !insIsStore && !ldFull;
    strobe.stPush = canIns && insIsStore && sizeOk && !stFull;
    strobe.ldPop  = !squashValid && (ldCount != '0) && boundValid && (ldHeadSeq <= bound);
    strobe.stMark = !squashValid && (eligCnt < stCount) && boundValid && (markSeq <= bound);
    strobe.stPop  = wbGo && (stHeadPrefetch || wrReady);
  end

  assign insOverflow = canIns && (insIsStore ? stFull : ldFull);
  assign sizeError   = canIns && insIsStore && !sizeOk;

  always_comb begin
    if (insIsStore) begin
      allocIdx       = stTail;
      allocPeer      = ldTail;
      allocPeerValid = 1'b1;
    end else begin
      allocIdx       = ldTail;
      allocPeer      = stTail;
      allocPeerValid = (stCount != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bound      <= '0;
      boundValid <= 1'b0;
    end else if (commitValid) begin
      bound      <= commitSeq;
      boundValid <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ldHead  <= '0;
      ldTail  <= '0;
      ldCount <= '0;
    end else if (squashValid) begin
      ldTail  <= wrapAdd(ldHead, ldKeep, LQ_SIZE);
      ldCount <= ldKeep;
    end else begin
      if (strobe.ldPush) ldTail <= wrapAdd(ldTail, CNT_W'(1), LQ_SIZE);
      if (strobe.ldPop)  ldHead <= wrapAdd(ldHead, CNT_W'(1), LQ_SIZE);
      ldCount <= ldCount + CNT_W'(strobe.ldPush) - CNT_W'(strobe.ldPop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stHead  <= '0;
      stTail  <= '0;
      stCount <= '0;
      eligCnt <= '0;
    end else if (squashValid) begin
      stTail  <= wrapAdd(stHead, stKeep, SQ_SIZE);
      stCount <= stKeep;
      eligCnt <= eligCnt - stFlagDrop;
    end else begin
      if (strobe.stPush) stTail <= wrapAdd(stTail, CNT_W'(1), SQ_SIZE);
      if (strobe.stPop)  stHead <= wrapAdd(stHead, CNT_W'(1), SQ_SIZE);
      stCount <= stCount + CNT_W'(strobe.stPush) - CNT_W'(strobe.stPop);
      eligCnt <= eligCnt + CNT_W'(strobe.stMark) - CNT_W'(strobe.stPop);
    end
  end

  // R2: occupancy never exceeds the configured capacity
  a_r2_load_cap: assert property (@(posedge clk) disable iff (!rstN)
    ldCount <= CNT_W'(LQ_CAP));
  a_r2_store_cap: assert property (@(posedge clk) disable iff (!rstN)
    stCount <= CNT_W'(SQ_CAP));

  // R2: the pointer distance and the occupancy register agree
  a_r2_load_ptrs: assert property (@(posedge clk) disable iff (!rstN)
    wrapAdd(ldHead, ldCount, LQ_SIZE) == ldTail);

  // R5: eligible stores are a subset of the held stores
  a_r5_elig_subset: assert property (@(posedge clk) disable iff (!rstN)
    eligCnt <= stCount);

  // R7: a blocked cache never sees a request and no store leaves
  a_r7_blocked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    cacheBlocked |=> $stable(stHead) || $past(squashValid) || !$past(cacheBlocked));

  // R8: a prefetch at the head is never offered to the cache
  a_r8_no_pf_write: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |-> !stHeadPrefetch);

  // R11: a squash cycle never grows either queue
  a_r11_squash_no_grow: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |=> (ldCount <= $past(ldCount)) && (stCount <= $past(stCount)));

endmodule

// File: rtl/mem_order_queue.sv
module mem_order_queue
  import moq_pkg::*;
#(
  parameter int LOAD_CAP  = 8,
  parameter int STORE_CAP = 8,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 64,
  localparam int MAX_SIZE = ((LOAD_CAP > STORE_CAP) ? LOAD_CAP : STORE_CAP) + 1,
  localparam int PTR_W    = $clog2(MAX_SIZE),
  localparam int CNT_W    = $clog2(MAX_SIZE + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              insValid,
  input  logic              insIsStore,
  input  logic [SEQ_W-1:0]  insSeq,
  input  logic [ADDR_W-1:0] insAddr,
  input  logic [DATA_W-1:0] insData,
  input  logic [3:0]        insSize,
  input  logic              insPrefetch,
  input  logic              commitValid,
  input  logic [SEQ_W-1:0]  commitSeq,
  input  logic              squashValid,
  input  logic [SEQ_W-1:0]  squashSeq,
  input  logic              cacheBlocked,
  input  logic              wrReady,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [3:0]        wrSize,
  output logic              insOverflow,
  output logic              sizeError,
  output logic [PTR_W-1:0]  allocIdx,
  output logic [PTR_W-1:0]  allocPeer,
  output logic              allocPeerValid,
  output logic [CNT_W-1:0]  loadCount,
  output logic [CNT_W-1:0]  storeCount,
  output logic [CNT_W-1:0]  eligibleCount
);

  moq_strobe_t      strobe;
  logic [PTR_W-1:0] ldHead, ldTail, stHead, stTail, markPtr;
  logic [CNT_W-1:0] ldKeep, stKeep, stFlagDrop;
  logic [SEQ_W-1:0] ldHeadSeq, markSeq;
  logic             stHeadFlag, stHeadPrefetch;

  moq_ctrl #(
    .LQ_CAP(LOAD_CAP), .SQ_CAP(STORE_CAP), .PTR_W(PTR_W), .CNT_W(CNT_W), .SEQ_W(SEQ_W)
  ) ctrl (
    .clk(clk), .rstN(rstN),
    .insValid(insValid), .insIsStore(insIsStore), .insSize(insSize),
    .commitValid(commitValid), .commitSeq(commitSeq),
    .squashValid(squashValid), .cacheBlocked(cacheBlocked), .wrReady(wrReady),
    .ldHeadSeq(ldHeadSeq), .stHeadFlag(stHeadFlag), .stHeadPrefetch(stHeadPrefetch),
    .markSeq(markSeq), .ldKeep(ldKeep), .stKeep(stKeep), .stFlagDrop(stFlagDrop),
    .strobe(strobe),
    .ldHead(ldHead), .ldTail(ldTail), .ldCount(loadCount),
    .stHead(stHead), .stTail(stTail), .stCount(storeCount),
    .eligCnt(eligibleCount), .markPtr(markPtr), .wrValid(wrValid),
    .insOverflow(insOverflow), .sizeError(sizeError),
    .allocIdx(allocIdx), .allocPeer(allocPeer), .allocPeerValid(allocPeerValid)
  );

  moq_data #(
    .LQ_SIZE(LOAD_CAP + 1), .SQ_SIZE(STORE_CAP + 1), .PTR_W(PTR_W), .CNT_W(CNT_W),
    .SEQ_W(SEQ_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) data (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldHead(ldHead), .ldTail(ldTail), .ldCount(loadCount),
    .stHead(stHead), .stTail(stTail), .stCount(storeCount),
    .markPtr(markPtr),
    .insSeq(insSeq), .insAddr(insAddr), .insData(insData), .insSize(insSize),
    .insPrefetch(insPrefetch), .squashSeq(squashSeq),
    .ldHeadSeq(ldHeadSeq), .stHeadFlag(stHeadFlag), .stHeadPrefetch(stHeadPrefetch),
    .headAddr(wrAddr), .headData(wrData), .headSize(wrSize),
    .markSeq(markSeq), .ldKeep(ldKeep), .stKeep(stKeep), .stFlagDrop(stFlagDrop)
  );

endmodule

// File: tb/mem_order_queue_test.sv
`timescale 1ns/100ps
module mem_order_queue_test;

  localparam int CAP = 3;
  localparam int SLOTS = CAP + 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        insValid = 0, insIsStore = 0, insPrefetch = 0;
  logic [7:0]  insSeq = 0, insAddr = 0;
  logic [15:0] insData = 0;
  logic [3:0]  insSize = 0;
  logic        commitValid = 0, squashValid = 0, cacheBlocked = 0, wrReady = 0;
  logic [7:0]  commitSeq = 0, squashSeq = 0;
  logic        wrValid, insOverflow, sizeError, allocPeerValid;
  logic [7:0]  wrAddr;
  logic [15:0] wrData;
  logic [3:0]  wrSize;
  logic [1:0]  allocIdx, allocPeer;
  logic [2:0]  loadCount, storeCount, eligibleCount;

  int checks = 0, errors = 0, writes = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  mem_order_queue #(.LOAD_CAP(CAP), .STORE_CAP(CAP), .SEQ_W(8), .ADDR_W(8), .DATA_W(16)) uut (
    .clk(clk), .rstN(rstN), .insValid(insValid), .insIsStore(insIsStore), .insSeq(insSeq),
    .insAddr(insAddr), .insData(insData), .insSize(insSize), .insPrefetch(insPrefetch),
    .commitValid(commitValid), .commitSeq(commitSeq), .squashValid(squashValid),
    .squashSeq(squashSeq), .cacheBlocked(cacheBlocked), .wrReady(wrReady),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData), .wrSize(wrSize),
    .insOverflow(insOverflow), .sizeError(sizeError), .allocIdx(allocIdx),
    .allocPeer(allocPeer), .allocPeerValid(allocPeerValid), .loadCount(loadCount),
    .storeCount(storeCount), .eligibleCount(eligibleCount)
  );

  always @(negedge clk) if (rstN && wrValid && wrReady) writes++;

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic setIns(input bit st, input int seq, input int addr, input int data,
                        input int size, input bit pf);
    insValid = 1; insIsStore = st; insSeq = 8'(seq); insAddr = 8'(addr);
    insData = 16'(data); insSize = 4'(size); insPrefetch = pf;
    settle();
  endtask

  task automatic endIns();
    tick();
    insValid = 0; insIsStore = 0; insPrefetch = 0;
  endtask

  task automatic pulseCommit(input int seq);
    commitValid = 1; commitSeq = 8'(seq);
    tick();
    commitValid = 0;
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    rstN = 1;
    tick();
    // R1: reset state
    chk("R1 loadCount", loadCount, 0);
    chk("R1 storeCount", storeCount, 0);
    chk("R1 eligibleCount", eligibleCount, 0);
    chk("R1 wrValid", wrValid, 0);

    // R3 and R2: three loads fill the load queue, the fourth overflows
    for (int i = 0; i < CAP; i++) begin
      setIns(0, i + 1, 0, 0, 0, 0);
      chk("R3 load allocIdx", allocIdx, i);
      chk("R3 load peer invalid", allocPeerValid, 0);
      chk("R2 no overflow", insOverflow, 0);
      endIns();
    end
    setIns(0, 9, 0, 0, 0, 0);
    chk("R2 overflow when full", insOverflow, 1);
    endIns();
    chk("R2 count unchanged", loadCount, CAP);

    // R4: bound 2 frees loads 1 and 2, one per cycle
    pulseCommit(2);
    chk("R4 latch cycle", loadCount, 3);
    tick(); chk("R4 first pop", loadCount, 2);
    tick(); chk("R4 second pop", loadCount, 1);
    tick(); chk("R4 stops above bound", loadCount, 1);

    // R3, R9, R2 on the store queue
    setIns(1, 4, 10, 16'h0011, 1, 0);
    chk("R3 store allocIdx", allocIdx, 0);
    chk("R3 store peer is load tail", allocPeer, 3);
    chk("R3 store peer valid", allocPeerValid, 1);
    chk("R9 size 1 legal", sizeError, 0);
    endIns();
    setIns(1, 99, 0, 0, 3, 0);
    chk("R9 size 3 flagged", sizeError, 1);
    endIns();
    chk("R9 size 3 not held", storeCount, 1);
    setIns(1, 5, 20, 16'h2222, 2, 0);
    chk("R9 size 2 legal", sizeError, 0);
    endIns();
    setIns(1, 6, 0, 0, 8, 1);
    chk("R9 size 8 legal", sizeError, 0);
    endIns();
    setIns(1, 50, 0, 0, 1, 0);
    chk("R2 store overflow", insOverflow, 1);
    endIns();
    chk("R2 store count", storeCount, 3);

    // R3: load inserted while stores are held
    setIns(0, 7, 0, 0, 0, 0);
    chk("R3 load allocIdx wrap", allocIdx, 3);
    chk("R3 load peer is store tail", allocPeer, 3);
    chk("R3 load peer valid", allocPeerValid, 1);
    endIns();

    // R5 and R7: bound 5 while cache blocked
    cacheBlocked = 1;
    pulseCommit(5);
    chk("R5 latch cycle", eligibleCount, 0);
    tick(); chk("R5 first mark", eligibleCount, 1);
    chk("R4 load 3 freed", loadCount, 1);
    tick(); chk("R5 second mark", eligibleCount, 2);
    tick(); chk("R5 stops at seq 6", eligibleCount, 2);
    chk("R4 load 7 kept", loadCount, 1);
    chk("R7 no request while blocked", wrValid, 0);
    chk("R7 no store freed", storeCount, 3);

    // R10 and R11: squash at 4 with a competing insert
    squashValid = 1; squashSeq = 8'd4;
    setIns(0, 8, 0, 0, 0, 0);
    chk("R11 no overflow on squash", insOverflow, 0);
    endIns();
    squashValid = 0;
    chk("R10 stores trimmed", storeCount, 1);
    chk("R10 flagged store dropped", eligibleCount, 1);
    chk("R10 R11 loads trimmed, no insert", loadCount, 0);

    setIns(1, 6, 0, 0, 8, 1);
    chk("R10 store tail moved back", allocIdx, 1);
    endIns();
    setIns(1, 7, 8'h30, 16'h7777, 4, 0);
    chk("R9 size 4 legal", sizeError, 0);
    endIns();
    pulseCommit(10);
    tick(); tick(); tick();
    chk("R5 all marked", eligibleCount, 3);
    chk("R7 still quiet", wrValid, 0);

    // R6 and R8: drain in order
    cacheBlocked = 0; wrReady = 0;
    settle();
    chk("R6 request raised", wrValid, 1);
    chk("R6 address", wrAddr, 10);
    chk("R6 data", wrData, 16'h0011);
    chk("R6 size", wrSize, 1);
    tick();
    chk("R6 held without ready", storeCount, 3);
    wrReady = 1;
    tick(); settle();
    chk("R6 first store freed", storeCount, 2);
    chk("R8 prefetch not offered", wrValid, 0);
    tick(); settle();
    chk("R8 prefetch freed", storeCount, 1);
    chk("R6 second request", wrValid, 1);
    chk("R6 second address", wrAddr, 8'h30);
    chk("R6 second data", wrData, 16'h7777);
    chk("R6 second size", wrSize, 4);
    tick();
    chk("R6 drained", storeCount, 0);
    chk("R6 eligible cleared", eligibleCount, 0);
    chk("R8 two cache writes", writes, 2);
    wrReady = 0;

    // R3 and R4: slot sweep across the wrap of the load queue
    for (int k = 0; k < 2 * SLOTS; k++) begin
      setIns(0, 20 + k, 0, 0, 0, 0);
      chk("R3 sweep allocIdx", allocIdx, (3 + k) % SLOTS);
      chk("R3 sweep peer invalid", allocPeerValid, 0);
      endIns();
      pulseCommit(20 + k);
      tick();
      chk("R4 sweep freed", loadCount, 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule